// File: doc/BRIEF.md
# HDLC Channel Status Word

This block builds the status word of a single HDLC channel. It collects conditions from the surrounding transmit and receive FIFOs, the frame transmitter and the active-low clear-to-send modem pin. It turns them into one registered 16-bit word and a registered interrupt request. Some bits follow their source every cycle. Others are sticky flags that capture a one-cycle event and stay set until software writes a one to that bit position.

The FIFO-availability bits depend on the transfer granularity. A channel moves data either one 32-bit word at a time or in bursts of four words. Whenever DMA owns a direction, that direction's availability bit is forced low, so the DMA engine is not disturbed by interrupts. The clear-to-send pin is resynchronised and reported twice: as a live level that never interrupts, and as a sticky flag that records each change of the pin.

Top module: `hdlc_stat_reg`

## Requirements
- R1: Bits [3:0] carry `rx_rem_bytes` (number of valid bytes in the last transfer unit, minus one). With `burst_mode`=0 (one-word transfers) only its two low bits are passed and bits [3:2] read 0. With `burst_mode`=1 (four-word bursts) all four bits are passed. Like every live bit, the field shows the inputs sampled at the previous clock edge.
- R2: Bit 4 (frame sent) becomes 1 one cycle after a cycle with `tx_close_sent` or `tx_abort_sent` high while the transmit FIFO is empty (`tx_free` equals the FIFO depth). Neither strobe sets it while the FIFO holds data.
- R3: Bit 5 (transmit space) is live. With `burst_mode`=0 it is 1 when `tx_free` is at least 1. With `burst_mode`=1 it is 1 when `tx_free` is at least 4.
- R4: While `tx_dma_en` is high, bit 5 reads 0. While `rx_dma_en` is high, bit 9 reads 0.
- R5: Bit 9 (receive data) is live. It is 1 when `rx_count` is at least 1 (`burst_mode`=0) or at least 4 (`burst_mode`=1), or when `rx_last_held` is high, whatever the count.
- R6: Bit 6 is the inverse of `cts_n` after a two-flop synchroniser. It follows a change of the pin three clock edges later. It never raises `irq`.
- R7: Bit 7 is sticky. It sets on every change of the synchronised `cts_n`, both falling and rising, in the same cycle that bit 6 changes.
- R8: Bit 8 (underrun) is sticky. It becomes 1 one cycle after a cycle with `tx_underrun` high.
- R9: A cycle with `clr_wr` high clears the sticky bits 4, 7 and 8 whose `clr_data` bit is 1. Other sticky bits and all live bits are unaffected. A set event in the same cycle as the clear leaves the bit at 1.
- R10: Bits [15:10] always read 0.
- R11: `irq` is registered. It equals the OR over bits 4, 5, 7, 8 and 9 of `status & irq_en`, taken one cycle earlier.
- R12: While `rst` is high, `status` and `irq` are 0 (with all inputs low and `cts_n` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 0 = one-word transfers, 1 = four-word bursts |
| tx_dma_en | input | 1 | Transmit direction served by DMA |
| rx_dma_en | input | 1 | Receive direction served by DMA |
| tx_free | input | LVL_W (4) | Empty word slots in the transmit FIFO |
| rx_count | input | LVL_W (4) | Words held in the receive FIFO |
| rx_last_held | input | 1 | Receive FIFO holds the entry marked as frame end |
| tx_close_sent | input | 1 | Strobe: closing flag transmitted |
| tx_abort_sent | input | 1 | Strobe: abort sequence transmitted |
| tx_underrun | input | 1 | Strobe: transmitter starved inside a frame |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| rx_rem_bytes | input | REM_W (4) | Valid byte count minus one of the final unit |
| clr_wr | input | 1 | Write strobe for clearing sticky bits |
| clr_data | input | 16 | Write-one-to-clear data |
| irq_en | input | 16 | Per-bit interrupt enable |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request level |

## Verification
The bench uses the default parameters: an 8-word FIFO depth, four-word bursts, four-byte words and a two-stage synchroniser. With 8 slots, both thresholds can be tested on each side of the boundary (3 versus 4, 0 versus 1), as well as a completely empty transmit FIFO. The 4-bit remaining-byte field shows its 1-word masking with values above 3. The two-stage synchroniser makes the clear-to-send latency exactly three edges, so the bench checks that neither CTS bit has changed one edge before that.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int STAT_W    = 16;
  // bit positions inside the status word
  localparam int B_REM_LO  = 0;
  localparam int B_FSENT   = 4;
  localparam int B_TXSPACE = 5;
  localparam int B_CTSLVL  = 6;
  localparam int B_CTSCHG  = 7;
  localparam int B_UNDER   = 8;
  localparam int B_RXDATA  = 9;
  localparam int N_STICKY  = 3;
  // bits allowed to request an interrupt
  localparam logic [STAT_W-1:0] IRQ_CAP =
    (STAT_W'(1) << B_FSENT) | (STAT_W'(1) << B_TXSPACE) |
    (STAT_W'(1) << B_CTSCHG) | (STAT_W'(1) << B_UNDER) |
    (STAT_W'(1) << B_RXDATA);
endpackage

// File: rtl/hdlc_stat_cts_sync.sv
module hdlc_stat_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              synced;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b1;
      lvl_o <= 1'b0;
    end else begin
      prev  <= synced;
      lvl_o <= ~synced;
    end
  end

  assign chg_o = synced ^ prev;

  // R6
  cts_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_o == !$past(synced)));
endmodule

// File: rtl/hdlc_stat_avail.sv
module hdlc_stat_avail #(
  parameter int LVL_W = 4,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_mode,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [LVL_W-1:0] tx_free,
  input  logic [LVL_W-1:0] rx_count,
  input  logic             rx_last_held,
  output logic             tx_space_o,
  output logic             rx_data_o
);
  localparam logic [LVL_W-1:0] ONE_UNIT   = LVL_W'(1);
  localparam logic [LVL_W-1:0] BURST_UNIT = LVL_W'(BURST);

  logic [LVL_W-1:0] need;
  logic             tx_ok, rx_ok;

  always_comb begin
    need  = burst_mode ? BURST_UNIT : ONE_UNIT;
    tx_ok = (tx_free >= need) && !tx_dma_en;
    rx_ok = ((rx_count >= need) || rx_last_held) && !rx_dma_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_space_o <= 1'b0;
      rx_data_o  <= 1'b0;
    end else begin
      tx_space_o <= tx_ok;
      rx_data_o  <= rx_ok;
    end
  end

  // R4
  tx_dma_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tx_dma_en |=> !tx_space_o);
  // R4
  rx_dma_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rx_dma_en |=> !rx_data_o);
  // R5
  rx_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_last_held && !rx_dma_en) |=> rx_data_o);
endmodule

// File: rtl/hdlc_stat_sticky.sv
module hdlc_stat_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) q_o[i] <= 1'b0;
        else     q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
      end

      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> q_o[i]);
      // R9
      clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end
  endgenerate
endmodule

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg
  import hdlc_stat_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int BURST       = 4,
  parameter int WORD_BYTES  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1),
  localparam int REM_W  = $clog2(WORD_BYTES * BURST),
  localparam int WREM_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_mode,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic [LVL_W-1:0]  tx_free,
  input  logic [LVL_W-1:0]  rx_count,
  input  logic              rx_last_held,
  input  logic              tx_close_sent,
  input  logic              tx_abort_sent,
  input  logic              tx_underrun,
  input  logic              cts_n,
  input  logic [REM_W-1:0]  rx_rem_bytes,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] irq_en,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [REM_W-1:0] WORD_MASK = REM_W'((1 << WREM_W) - 1);

  logic                cts_lvl, cts_chg;
  logic                tx_space, rx_data;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [REM_W-1:0]    rem_q;
  logic                tx_empty;

  hdlc_stat_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst(rst), .pin_n(cts_n), .lvl_o(cts_lvl), .chg_o(cts_chg)
  );

  hdlc_stat_avail #(.LVL_W(LVL_W), .BURST(BURST)) u_avail (
    .clk(clk), .rst(rst), .burst_mode(burst_mode),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_free(tx_free), .rx_count(rx_count), .rx_last_held(rx_last_held),
    .tx_space_o(tx_space), .rx_data_o(rx_data)
  );

  assign tx_empty = (tx_free == LVL_W'(FIFO_DEPTH));

  // sticky slots: 0 = frame sent, 1 = CTS change, 2 = underrun
  always_comb begin
    st_set[0] = tx_empty && (tx_close_sent || tx_abort_sent);
    st_set[1] = cts_chg;
    st_set[2] = tx_underrun;
    st_clr[0] = clr_wr && clr_data[B_FSENT];
    st_clr[1] = clr_wr && clr_data[B_CTSCHG];
    st_clr[2] = clr_wr && clr_data[B_UNDER];
  end

  hdlc_stat_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .q_o(st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= burst_mode ? rx_rem_bytes : (rx_rem_bytes & WORD_MASK);
  end

  always_comb begin
    status = '0;
    status[B_REM_LO +: REM_W] = rem_q;
    status[B_FSENT]   = st_q[0];
    status[B_TXSPACE] = tx_space;
    status[B_CTSLVL]  = cts_lvl;
    status[B_CTSCHG]  = st_q[1];
    status[B_UNDER]   = st_q[2];
    status[B_RXDATA]  = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & irq_en & IRQ_CAP);
  end

  // R11
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status) & $past(irq_en) & IRQ_CAP)));
  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> status[B_UNDER]);
  // R2
  fsent_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !clr_wr && !status[B_FSENT]) |=> !status[B_FSENT]);
  // R7
  cts_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (status[B_CTSLVL] != $past(status[B_CTSLVL])) |-> status[B_CTSCHG]);
endmodule

// File: tb/sim_hdlc_stat_reg.sv
module sim_hdlc_stat_reg;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, burst_mode, tx_dma_en, rx_dma_en, rx_last_held;
  logic [3:0]  tx_free, rx_count, rx_rem_bytes;
  logic        tx_close_sent, tx_abort_sent, tx_underrun, cts_n, clr_wr;
  logic [15:0] clr_data, irq_en, status;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  hdlc_stat_reg u0 (
    .clk(clk), .rst(rst), .burst_mode(burst_mode), .tx_dma_en(tx_dma_en),
    .rx_dma_en(rx_dma_en), .tx_free(tx_free), .rx_count(rx_count),
    .rx_last_held(rx_last_held), .tx_close_sent(tx_close_sent),
    .tx_abort_sent(tx_abort_sent), .tx_underrun(tx_underrun), .cts_n(cts_n),
    .rx_rem_bytes(rx_rem_bytes), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  typedef struct packed {
    logic       mode, tdma, rdma;
    logic [3:0] txf, rxc;
    logic       last;
    logic [3:0] rem;
    logic [15:0] exp;
  } vec_t;

  // live-bit vectors (R1 R3 R4 R5), cts_n high, no strobes
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0,4'd0,4'd0,1'b0,4'd7, 16'h0003},
    '{1'b0,1'b0,1'b0,4'd1,4'd1,1'b0,4'd2, 16'h0222},
    '{1'b1,1'b0,1'b0,4'd3,4'd3,1'b0,4'd15,16'h000F},
    '{1'b1,1'b0,1'b0,4'd4,4'd4,1'b0,4'd9, 16'h0229},
    '{1'b1,1'b0,1'b0,4'd8,4'd2,1'b1,4'd0, 16'h0220},
    '{1'b1,1'b1,1'b1,4'd8,4'd8,1'b1,4'd0, 16'h0000},
    '{1'b0,1'b1,1'b0,4'd5,4'd0,1'b1,4'd0, 16'h0200},
    '{1'b0,1'b0,1'b1,4'd2,4'd5,1'b0,4'd13,16'h0021}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; burst_mode = 0; tx_dma_en = 0; rx_dma_en = 0; rx_last_held = 0;
    tx_free = 0; rx_count = 0; rx_rem_bytes = 0; tx_close_sent = 0;
    tx_abort_sent = 0; tx_underrun = 0; cts_n = 1; clr_wr = 0;
    clr_data = 0; irq_en = 0;
    tick(3);
    check("R12 status", status, 16'h0000);
    check("R12 irq", {15'd0, irq}, 16'h0000);
    rst = 1'b0;
    tick(1);

    for (int i = 0; i < 8; i++) begin
      burst_mode = VECS[i].mode; tx_dma_en = VECS[i].tdma; rx_dma_en = VECS[i].rdma;
      tx_free = VECS[i].txf; rx_count = VECS[i].rxc;
      rx_last_held = VECS[i].last; rx_rem_bytes = VECS[i].rem;
      tick(1);
      check("R1/R3/R4/R5 vector", status, VECS[i].exp);
    end

    // frame sent and clearing (R2 R9)
    burst_mode = 0; tx_dma_en = 0; rx_dma_en = 0; rx_last_held = 0;
    rx_count = 0; rx_rem_bytes = 0; tx_free = 8;
    tick(1);
    tx_close_sent = 1; tick(1); tx_close_sent = 0;
    check("R2 close on empty", status, 16'h0030);
    clr_wr = 1; clr_data = 16'h0020; tick(1); clr_wr = 0;
    check("R9 live bit unaffected", status, 16'h0030);
    clr_wr = 1; clr_data = 16'h0010; tick(1); clr_wr = 0;
    check("R9 clear frame sent", status, 16'h0020);
    tx_free = 3; tx_abort_sent = 1; tick(1); tx_abort_sent = 0;
    check("R2 abort not empty", status, 16'h0020);
    tx_free = 8; tx_abort_sent = 1; clr_wr = 1; clr_data = 16'h0010;
    tick(1); tx_abort_sent = 0; clr_wr = 0;
    check("R9 set wins over clear", status, 16'h0030);

    // underrun and irq timing (R8 R11)
    tx_underrun = 1; tick(1); tx_underrun = 0;
    check("R8 underrun", status, 16'h0130);
    irq_en = 16'h0100; tick(1);
    check("R11 irq high", {15'd0, irq}, 16'h0001);
    clr_wr = 1; clr_data = 16'h0100; tick(1); clr_wr = 0;
    check("R9 clear underrun keeps frame sent", status, 16'h0030);
    check("R11 irq lags status", {15'd0, irq}, 16'h0001);
    tick(1);
    check("R11 irq dropped", {15'd0, irq}, 16'h0000);
    tx_underrun = 1; tick(1); tx_underrun = 0;
    check("R11 irq not yet", {15'd0, irq}, 16'h0000);
    tick(1);
    check("R11 irq raised", {15'd0, irq}, 16'h0001);
    clr_wr = 1; clr_data = 16'h0110; tx_free = 0; tick(1); clr_wr = 0;
    tick(1);
    check("R9 all sticky clear", status, 16'h0000);

    // CTS (R6 R7)
    irq_en = 16'h0040;
    cts_n = 0; tick(2);
    check("R6 latency not early", status, 16'h0000);
    tick(1);
    check("R6/R7 CTS low seen", status, 16'h00C0);
    tick(1);
    check("R6 no irq from level", {15'd0, irq}, 16'h0000);
    clr_wr = 1; clr_data = 16'h0080; tick(1); clr_wr = 0;
    check("R9 clear CTS change", status, 16'h0040);
    cts_n = 1; tick(3);
    check("R7 rising change", status, 16'h0080);
    irq_en = 16'h0080; tick(2);
    check("R11 irq from CTS change", {15'd0, irq}, 16'h0001);

    // reserved bits (R10)
    clr_wr = 1; clr_data = 16'hFFFF; tick(1); clr_wr = 0;
    check("R10 reserved zero", status & 16'hFC00, 16'h0000);
    check("R9 clear all", status, 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule